// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the main control unit of a single-cycle 32-bit processor core. It takes the instruction word currently being executed and, with no internal state, produces every datapath control line. The core uses these lines to choose the register file write enable and write address, the second ALU operand, the ALU function, the data memory strobes, the writeback source, and the next-PC choice among sequential, conditional branch, absolute jump and register-indirect jump.

The supported set covers register-to-register arithmetic (add, subtract, and, or, set-less-than, multiply), add-immediate, word load and store, absolute jump, jump-and-link, jump through a register, and four conditional branches: equal, less-or-equal, not-equal-to-zero and less-than-zero. Several of these share opcode 0, so they can only be told apart by also inspecting the function field and the fields that must be zero. Any word that does not match a supported encoding exactly, the all-zero NOP among them, produces all outputs low.

Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0]. ALU operation codes: 0 add, 1 subtract, 2 and, 3 or, 4 set-less-than, 5 multiply. Branch kind codes: 0 equal, 1 less-or-equal, 2 not-zero, 3 less-than-zero.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 6'b100011 (load word) drives reg_write=1, alu_src=1, alu_op=0, mem_read=1, mem_to_reg=1, reg_dst=0 (destination in rt), and every other output 0.
- R2: Opcode 6'b101011 (store word) drives mem_write=1, alu_src=1, alu_op=0, and every other output 0. In particular, reg_write is 0.
- R3: Opcode 0 with shamt 0 and funct 6'b100000/100010/100100/100101/101010 drives reg_write=1, reg_dst=1, alu_op 0/1/2/3/4 in that order, and every other output 0.
- R4: Opcode 0, shamt 0, funct 6'b011000 (multiply) drives reg_write=1, reg_dst=1, alu_op=5, and every other output 0.
- R5: Opcode 0, funct 6'b001000, with rt, rd and shamt all zero (jump-register) drives jump_reg=1 and every other output 0, including reg_write. If any of rt, rd or shamt is nonzero, every output is 0.
- R6: Opcode 6'b000010 drives jump=1 only. Opcode 6'b000011 drives jump=1, reg_write=1, link=1 and every other output 0.
- R7: Branches drive branch=1, alu_op=1 and br_type, with every other output 0. Opcode 6'b000100 gives br_type 0, and opcode 6'b000110 gives br_type 1; for both, any rt is allowed. Opcode 6'b000101 with rt=0 gives br_type 2. Opcode 6'b000001 with rt=0 gives br_type 3.
- R8: Opcodes 6'b000101 and 6'b000001 with a nonzero rt field drive every output 0.
- R9: The all-zero instruction word (NOP) drives every output 0.
- R10: Any unlisted opcode, and any opcode-0 word whose funct is unlisted or whose shamt is nonzero, drives every output 0.
- R11: Opcode 6'b001000 (add immediate) drives reg_write=1, alu_src=1, alu_op=0 and every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| reg_write | output | 1 | Register file write enable |
| reg_dst | output | 1 | Write address from rd (1) or rt (0) |
| alu_src | output | 1 | Second ALU operand is the sign-extended immediate |
| alu_op | output | 3 | ALU operation code |
| mem_read | output | 1 | Data memory read strobe |
| mem_write | output | 1 | Data memory write strobe |
| mem_to_reg | output | 1 | Writeback data comes from memory |
| branch | output | 1 | Conditional branch instruction |
| br_type | output | 2 | Branch condition kind |
| jump | output | 1 | Absolute jump to the target in the address field |
| jump_reg | output | 1 | Jump to the address held in rs |
| link | output | 1 | Force write address to register 31 with data PC+4 |

## Verification
The bench goes after the encodings that share opcode 0. A jump-register that leaks reg_write would overwrite rd (normally r0) on every return. A decoder that ignores shamt or the zero fields would accept malformed words as valid instructions. A NOP that falls through to the add path would raise reg_write. It also probes the two zero-compare branches with a nonzero rt, which a decoder that looks only at the opcode would wrongly accept as branches. In addition, store must never raise reg_write, and jump-and-link must raise link together with reg_write. Random words with both free and forced opcodes are compared against a behavioural model, so any stray output bit on an undefined encoding shows up.

// File: rtl/ctrl_decoder.sv
module ctrl_decoder (
  input  logic [31:0] instr,
  output logic        reg_write,
  output logic        reg_dst,
  output logic        alu_src,
  output logic [2:0]  alu_op,
  output logic        mem_read,
  output logic        mem_write,
  output logic        mem_to_reg,
  output logic        branch,
  output logic [1:0]  br_type,
  output logic        jump,
  output logic        jump_reg,
  output logic        link
);
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_BLTZ    = 6'b000001;
  localparam logic [5:0] OP_J       = 6'b000010;
  localparam logic [5:0] OP_JAL     = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNEZ    = 6'b000101;
  localparam logic [5:0] OP_BLE     = 6'b000110;
  localparam logic [5:0] OP_ADDI    = 6'b001000;
  localparam logic [5:0] OP_LW      = 6'b100011;
  localparam logic [5:0] OP_SW      = 6'b101011;

  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_MUL = 6'b011000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [2:0] ALU_ADD = 3'd0;
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_AND = 3'd2;
  localparam logic [2:0] ALU_OR  = 3'd3;
  localparam logic [2:0] ALU_SLT = 3'd4;
  localparam logic [2:0] ALU_MUL = 3'd5;

  localparam logic [1:0] BR_EQ  = 2'd0;
  localparam logic [1:0] BR_LE  = 2'd1;
  localparam logic [1:0] BR_NEZ = 2'd2;
  localparam logic [1:0] BR_LTZ = 2'd3;

  wire [5:0] opcode = instr[31:26];
  wire [4:0] rt     = instr[20:16];
  wire [4:0] rd     = instr[15:11];
  wire [4:0] shamt  = instr[10:6];
  wire [5:0] funct  = instr[5:0];

  wire rt_zero    = (rt == 5'd0);
  wire shamt_zero = (shamt == 5'd0);
  wire jr_fields  = rt_zero && (rd == 5'd0) && shamt_zero;

  always_comb begin
    reg_write  = 1'b0;
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    alu_op     = ALU_ADD;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    mem_to_reg = 1'b0;
    branch     = 1'b0;
    br_type    = BR_EQ;
    jump       = 1'b0;
    jump_reg   = 1'b0;
    link       = 1'b0;
    unique case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JR) begin
          jump_reg = jr_fields;
        end else if (shamt_zero) begin
          reg_write = 1'b1;
          reg_dst   = 1'b1;
          case (funct)
            FN_ADD:  alu_op = ALU_ADD;
            FN_SUB:  alu_op = ALU_SUB;
            FN_AND:  alu_op = ALU_AND;
            FN_OR:   alu_op = ALU_OR;
            FN_SLT:  alu_op = ALU_SLT;
            FN_MUL:  alu_op = ALU_MUL;
            default: begin
              reg_write = 1'b0;
              reg_dst   = 1'b0;
            end
          endcase
        end
      end
      OP_LW: begin
        reg_write  = 1'b1;
        alu_src    = 1'b1;
        mem_read   = 1'b1;
        mem_to_reg = 1'b1;
      end
      OP_SW: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OP_ADDI: begin
        reg_write = 1'b1;
        alu_src   = 1'b1;
      end
      OP_J: jump = 1'b1;
      OP_JAL: begin
        jump      = 1'b1;
        reg_write = 1'b1;
        link      = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = ALU_SUB;
      end
      OP_BLE: begin
        branch  = 1'b1;
        alu_op  = ALU_SUB;
        br_type = BR_LE;
      end
      OP_BNEZ: if (rt_zero) begin
        branch  = 1'b1;
        alu_op  = ALU_SUB;
        br_type = BR_NEZ;
      end
      OP_BLTZ: if (rt_zero) begin
        branch  = 1'b1;
        alu_op  = ALU_SUB;
        br_type = BR_LTZ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic [31:0] instr,
  input logic        reg_write,
  input logic        mem_read,
  input logic        mem_write,
  input logic        mem_to_reg,
  input logic        branch,
  input logic        jump,
  input logic        jump_reg,
  input logic        link
);
  always_comb begin
    AST_MEM_EXCL: assert (!(mem_read && mem_write)) else $error("memory strobes together"); // R1
    AST_WB_FROM_MEM: assert (!mem_to_reg || mem_read) else $error("mem_to_reg without read"); // R1
    AST_STORE_NO_WB: assert (!mem_write || !reg_write) else $error("store writes register"); // R2
    AST_JR_ALONE: assert (!jump_reg || !(reg_write || jump || branch)) else $error("jr mixed"); // R5
    AST_LINK_WB: assert (!link || (jump && reg_write)) else $error("link without jump/write"); // R6
    AST_BR_NO_WB: assert (!branch || !(reg_write || mem_write || jump)) else $error("branch mixed"); // R7
    AST_NOP_QUIET: assert (instr != 32'd0 || !(reg_write || mem_write || mem_read)) else $error("nop active"); // R9
  end
endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
  .instr(instr), .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write),
  .mem_to_reg(mem_to_reg), .branch(branch), .jump(jump), .jump_reg(jump_reg), .link(link)
);

// File: tb/sim_ctrl_decoder.sv
module sim_ctrl_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr = 32'd0;
  logic reg_write, reg_dst, alu_src, mem_read, mem_write, mem_to_reg, branch, jump, jump_reg, link;
  logic [2:0] alu_op;
  logic [1:0] br_type;

  ctrl_decoder u0 (
    .instr(instr), .reg_write(reg_write), .reg_dst(reg_dst), .alu_src(alu_src),
    .alu_op(alu_op), .mem_read(mem_read), .mem_write(mem_write), .mem_to_reg(mem_to_reg),
    .branch(branch), .br_type(br_type), .jump(jump), .jump_reg(jump_reg), .link(link)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // packed: rw,rdst,asrc,aop[2:0],mrd,mwr,m2r,br,bt[1:0],j,jr,lk
  function automatic logic [14:0] pack(bit rw, bit rdst, bit asrc, int aop, bit mrd, bit mwr,
                                       bit m2r, bit br, int bt, bit j, bit jr, bit lk);
    return {rw, rdst, asrc, 3'(aop), mrd, mwr, m2r, br, 2'(bt), j, jr, lk};
  endfunction

  function automatic logic [14:0] model(logic [31:0] w);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    int rt = int'(w[20:16]);
    int rd = int'(w[15:11]);
    int sh = int'(w[10:6]);
    if (op == 35) return pack(1,0,1,0,1,0,1,0,0,0,0,0);
    if (op == 43) return pack(0,0,1,0,0,1,0,0,0,0,0,0);
    if (op == 8)  return pack(1,0,1,0,0,0,0,0,0,0,0,0);
    if (op == 2)  return pack(0,0,0,0,0,0,0,0,0,1,0,0);
    if (op == 3)  return pack(1,0,0,0,0,0,0,0,0,1,0,1);
    if (op == 4)  return pack(0,0,0,1,0,0,0,1,0,0,0,0);
    if (op == 6)  return pack(0,0,0,1,0,0,0,1,1,0,0,0);
    if (op == 5 && rt == 0) return pack(0,0,0,1,0,0,0,1,2,0,0,0);
    if (op == 1 && rt == 0) return pack(0,0,0,1,0,0,0,1,3,0,0,0);
    if (op == 0) begin
      if (fn == 8 && rt == 0 && rd == 0 && sh == 0) return pack(0,0,0,0,0,0,0,0,0,0,1,0);
      if (sh == 0) begin
        if (fn == 32) return pack(1,1,0,0,0,0,0,0,0,0,0,0);
        if (fn == 34) return pack(1,1,0,1,0,0,0,0,0,0,0,0);
        if (fn == 36) return pack(1,1,0,2,0,0,0,0,0,0,0,0);
        if (fn == 37) return pack(1,1,0,3,0,0,0,0,0,0,0,0);
        if (fn == 42) return pack(1,1,0,4,0,0,0,0,0,0,0,0);
        if (fn == 24) return pack(1,1,0,5,0,0,0,0,0,0,0,0);
      end
    end
    return 15'd0;
  endfunction

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic apply(logic [31:0] w, string req);
    logic [14:0] got, exp;
    @(posedge clk);
    #2 instr = w;
    @(negedge clk);
    got = {reg_write, reg_dst, alu_src, alu_op, mem_read, mem_write, mem_to_reg,
           branch, br_type, jump, jump_reg, link};
    exp = model(w);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%h actual=%b expected=%b", req, w, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply(32'd0, "R9");                         // reset state: NOP word
    apply(itype(35, 29, 8, 16'hfffc), "R1");
    apply(itype(43, 29, 31, 4), "R2");
    apply(itype(8, 0, 9, 10), "R11");
    apply(rtype(8, 9, 10, 0, 32), "R3");
    apply(rtype(8, 9, 10, 0, 34), "R3");
    apply(rtype(8, 9, 10, 0, 36), "R3");
    apply(rtype(8, 9, 10, 0, 37), "R3");
    apply(rtype(8, 9, 10, 0, 42), "R3");
    apply(rtype(9, 9, 11, 0, 24), "R4");
    apply(rtype(9, 9, 11, 3, 24), "R10");        // mul with shamt
    apply(rtype(31, 0, 0, 0, 8), "R5");
    apply(rtype(31, 1, 0, 0, 8), "R5");
    apply(rtype(31, 0, 5, 0, 8), "R5");
    apply(rtype(31, 0, 0, 2, 8), "R5");
    apply({6'd2, 26'h0000400}, "R6");
    apply({6'd3, 26'h3ffffff}, "R6");
    apply(itype(4, 1, 2, 16'hfffe), "R7");
    apply(itype(6, 8, 9, 5), "R7");
    apply(itype(5, 8, 0, 3), "R7");
    apply(itype(1, 12, 0, 16'h8000), "R7");
    apply(itype(5, 8, 7, 3), "R8");
    apply(itype(1, 12, 1, 3), "R8");
    apply(itype(15, 0, 9, 7), "R10");
    apply(rtype(1, 2, 3, 0, 0), "R10");         // shift-style funct
    apply(rtype(1, 2, 3, 4, 32), "R10");
    apply(32'hffffffff, "R10");
    apply(32'd0, "R9");
    for (int i = 0; i < 300; i++) apply($urandom, "R10");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w = $urandom;
      int pick = int'($urandom % 10);
      int ops[10] = '{0, 0, 1, 2, 3, 4, 5, 6, 35, 43};
      w[31:26] = 6'(ops[pick]);
      if ($urandom % 2 == 0) w[10:6] = 5'd0;
      if ($urandom % 3 == 0) w[20:16] = 5'd0;
      apply(w, "R3/R5/R7/R8");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule